// File: doc/BRIEF.md
# Delay-Slot Program Counter Unit

This unit owns the program counter of a processor whose branches and jumps each carry one delay slot. It presents the fetch address `pc`. In the same cycle it receives the instruction word fetched from that address and the two source-register values the instruction names. It decodes the control-transfer forms and evaluates the branch condition. It then computes the target and, for a taken transfer, holds that target for one instruction.

The instruction fetched right after a control transfer always runs. The redirect takes effect on the fetch after it. Linking jumps also raise a write request for register 31, with the return address beside it. Fetch memory, the register file and exception handling all belong to neighbouring blocks.

Top module: `dslot_pc_unit`

## Requirements
- R1: A synchronous, active-high `rst` sets `pc` to the parameter `START_PC` and discards any held target, so the fetch after reset is at `START_PC + 4`.
- R2: With no target held, `pc` advances by 4 on each clock.
- R3: The fetch following a taken transfer is always at the transfer's address + 4 (the delay slot).
- R4: On the clock after the delay slot, `pc` becomes the held target. For a non-taken transfer it continues at address + 8.
- R5: A branch target is the branch address + 4 + 4 × sign-extended `insn[15:0]`.
- R6: Branch conditions are decoded from opcode `insn[31:26]`. Opcode 4 is taken when rs = rt, and opcode 5 when rs ≠ rt. Opcode 6 is taken when rs ≤ 0 and opcode 7 when rs > 0. Opcode 1 is taken when rs < 0 if `insn[20:16]`=0, and when rs ≥ 0 if `insn[20:16]`=1. All single-register compares are signed.
- R7: Opcodes 2 and 3 jump to {address[31:28], `insn[25:0]`, 2'b00}, taking the upper bits from the jump's own address.
- R8: Opcode 0 with function `insn[5:0]` = 8 or 9 jumps to the full 32-bit rs value.
- R9: Opcode 3 and opcode 0 with function 9 raise `link_we` with `link_data` = address + 8, meant for register 31. All other instructions keep `link_we` low.
- R10: `xfer_taken` is high, in the same cycle, exactly when the instruction at `pc` is a taken transfer. Any other instruction word leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn | input | 32 | Instruction word fetched from `pc` |
| rs_val | input | 32 | Value of the register named by `insn[25:21]` |
| rt_val | input | 32 | Value of the register named by `insn[20:16]` |
| pc | output | 32 | Current fetch address |
| xfer_taken | output | 1 | Instruction at `pc` is a taken transfer |
| link_we | output | 1 | Write the return address to register 31 |
| link_data | output | 32 | Return address (address + 8) |

## Verification
The checks assume that no control-transfer instruction ever sits in a delay slot. They also assume that `insn`, `rs_val` and `rt_val` are settled whenever reset is low. Every stimulus vector starts from reset and follows each transfer with a no-op in its slot. The directed cases do the same, so the held target is always drained before another transfer is decoded. The slot and redirect properties therefore hold only because the stimulus respects this rule.

// File: rtl/dslot_pc_unit.sv
module dslot_pc_unit #(
  parameter logic [31:0] START_PC = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] insn,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc,
  output logic        xfer_taken,
  output logic        link_we,
  output logic [31:0] link_data
);

  logic [31:0] pc_q, tgt_q, tgt_d;
  logic        pend_q, take_d, link_d;

  wire [5:0]  op    = insn[31:26];
  wire [4:0]  rtsel = insn[20:16];
  wire [5:0]  fn    = insn[5:0];
  wire [31:0] seq4  = pc_q + 32'd4;
  wire [31:0] br_t  = seq4 + {{14{insn[15]}}, insn[15:0], 2'b00};
  wire [31:0] jp_t  = {pc_q[31:28], insn[25:0], 2'b00};
  wire        rs_neg  = rs_val[31];
  wire        rs_zero = (rs_val == 32'd0);

  always_comb begin
    take_d = 1'b0;
    link_d = 1'b0;
    tgt_d  = br_t;
    case (op)
      6'd0: if (fn == 6'd8 || fn == 6'd9) begin
              take_d = 1'b1;
              link_d = (fn == 6'd9);
              tgt_d  = rs_val;
            end
      6'd1: begin
              if (rtsel == 5'd0) take_d = rs_neg;
              else if (rtsel == 5'd1) take_d = !rs_neg;
            end
      6'd2: begin take_d = 1'b1; tgt_d = jp_t; end
      6'd3: begin take_d = 1'b1; link_d = 1'b1; tgt_d = jp_t; end
      6'd4: take_d = (rs_val == rt_val);
      6'd5: take_d = (rs_val != rt_val);
      6'd6: take_d = rs_neg || rs_zero;
      6'd7: take_d = !rs_neg && !rs_zero;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= START_PC;
      pend_q <= 1'b0;
      tgt_q  <= 32'd0;
    end else begin
      pc_q   <= pend_q ? tgt_q : seq4;
      pend_q <= take_d;
      tgt_q  <= tgt_d;
    end
  end

  assign pc         = pc_q;
  assign xfer_taken = take_d;
  assign link_we    = link_d;
  assign link_data  = pc_q + 32'd8;

endmodule

// File: rtl/dslot_pc_chk.sv
module dslot_pc_chk #(
  parameter logic [31:0] START_PC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        xfer_taken,
  input logic        link_we,
  input logic        pend_q,
  input logic [31:0] tgt_q
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pc == START_PC && !pend_q));

  p_seq_r2: assert property (@(posedge clk) disable iff (rst)
    !pend_q |=> pc == $past(pc) + 32'd4);

  p_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_taken && !pend_q) |=> pc == $past(pc) + 32'd4);

  p_redirect_r4: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> pc == $past(tgt_q));

  p_link_r9: assert property (@(posedge clk) disable iff (rst)
    link_we |-> xfer_taken);

endmodule

bind dslot_pc_unit dslot_pc_chk #(.START_PC(START_PC)) u_chk (
  .clk(clk), .rst(rst), .pc(pc), .xfer_taken(xfer_taken),
  .link_we(link_we), .pend_q(pend_q), .tgt_q(tgt_q)
);

// File: tb/sim_dslot_pc_unit.sv
module sim_dslot_pc_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] START = 32'h0040_0000;
  localparam logic [31:0] NOP = 32'h0000_0000;
  localparam int NV = 18;
  // {insn, rs, rt, expected pc after slot, taken, link}
  localparam logic [129:0] VEC [0:NV-1] = '{
    {32'h1022_0003, 32'h0000_0005, 32'h0000_0005, 32'h0040_0010, 1'b1, 1'b0},
    {32'h1022_0003, 32'h0000_0005, 32'h0000_0006, 32'h0040_0008, 1'b0, 1'b0},
    {32'h1422_FFFE, 32'h0000_0001, 32'h0000_0002, 32'h003F_FFFC, 1'b1, 1'b0},
    {32'h1422_FFFE, 32'h0000_0007, 32'h0000_0007, 32'h0040_0008, 1'b0, 1'b0},
    {32'h1820_0004, 32'h0000_0000, 32'h0000_0000, 32'h0040_0014, 1'b1, 1'b0},
    {32'h1820_0004, 32'h0000_0001, 32'h0000_0000, 32'h0040_0008, 1'b0, 1'b0},
    {32'h1820_0004, 32'hFFFF_FFF0, 32'h0000_0000, 32'h0040_0014, 1'b1, 1'b0},
    {32'h1C20_0004, 32'h8000_0000, 32'h0000_0000, 32'h0040_0008, 1'b0, 1'b0},
    {32'h1C20_0004, 32'h0000_0001, 32'h0000_0000, 32'h0040_0014, 1'b1, 1'b0},
    {32'h0420_0004, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0040_0014, 1'b1, 1'b0},
    {32'h0420_0004, 32'h0000_0000, 32'h0000_0000, 32'h0040_0008, 1'b0, 1'b0},
    {32'h0421_0004, 32'h0000_0000, 32'h0000_0000, 32'h0040_0014, 1'b1, 1'b0},
    {32'h0421_0004, 32'h8000_0000, 32'h0000_0000, 32'h0040_0008, 1'b0, 1'b0},
    {32'h0810_0004, 32'h0000_0000, 32'h0000_0000, 32'h0040_0010, 1'b1, 1'b0},
    {32'h0C10_0008, 32'h0000_0000, 32'h0000_0000, 32'h0040_0020, 1'b1, 1'b1},
    {32'h0020_0008, 32'h1234_5678, 32'h0000_0000, 32'h1234_5678, 1'b1, 1'b0},
    {32'h0020_F809, 32'hCAFE_BAB0, 32'h0000_0000, 32'hCAFE_BAB0, 1'b1, 1'b1},
    {32'h0064_1020, 32'h0000_0001, 32'h0000_0002, 32'h0040_0008, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] insn = NOP, rs_val = '0, rt_val = '0;
  logic [31:0] pc, link_data;
  logic xfer_taken, link_we;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  dslot_pc_unit #(.START_PC(START)) u0 (
    .clk(clk), .rst(rst), .insn(insn), .rs_val(rs_val), .rt_val(rt_val),
    .pc(pc), .xfer_taken(xfer_taken), .link_we(link_we), .link_data(link_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk); #1;
    insn = i; rs_val = a; rt_val = b;
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst = 1'b1; insn = NOP;
    @(posedge clk); #1; rst = 1'b0;
  endtask

  initial begin
    // R1: reset state
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pc", pc, START);
    chk("R9 no link at reset", {31'd0, link_we}, 32'd0);
    // R2: straight-line fetch
    for (int k = 1; k <= 3; k++) begin
      step(NOP, 0, 0);
      @(negedge clk);
      chk("R2 sequential pc", pc, START + 32'(4 * k));
    end

    // Vector table: R3..R10
    for (int v = 0; v < NV; v++) begin
      logic [31:0] vi, va, vb, vn;
      logic vt, vl;
      {vi, va, vb, vn, vt, vl} = VEC[v];
      do_reset();
      insn = vi; rs_val = va; rt_val = vb;
      @(negedge clk);
      chk("R10 xfer_taken", {31'd0, xfer_taken}, {31'd0, vt});
      chk("R9 link_we", {31'd0, link_we}, {31'd0, vl});
      if (vl) chk("R9 link_data", link_data, START + 32'd8);
      step(NOP, 0, 0);
      @(negedge clk);
      chk("R3 delay slot pc", pc, START + 32'd4);
      @(negedge clk);
      chk("R4 R5 R6 R7 R8 pc after slot", pc, vn);
    end

    // R7: upper address bits come from the jump's own address
    do_reset();
    insn = 32'h0020_0008; rs_val = 32'hA000_0000;
    step(NOP, 0, 0);
    step(32'h0800_0004, 0, 0);
    @(negedge clk);
    chk("R8 register jump target", pc, 32'hA000_0000);
    step(NOP, 0, 0);
    @(negedge clk);
    chk("R3 slot after jump", pc, 32'hA000_0004);
    step(32'h0C00_0040, 0, 0);
    @(negedge clk);
    chk("R7 absolute jump keeps upper bits", pc, 32'hA000_0010);
    chk("R9 link_data high region", link_data, 32'hA000_0018);
    step(NOP, 0, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R7 linked jump target", pc, 32'hA000_0100);

    // R1: reset discards a held target
    do_reset();
    insn = 32'h0810_0004;
    @(posedge clk); #1; rst = 1'b1; insn = NOP;
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pc with held target", pc, START);
    @(negedge clk);
    chk("R1 held target discarded", pc, START + 32'd4);

    // R5: largest forward offset
    do_reset();
    insn = 32'h1000_7FFF;
    step(NOP, 0, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R5 max forward offset", pc, START + 32'd4 + 32'h0001_FFFC);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule